// File: doc/BRIEF.md
# Byte Register Bank Behind an I2C Target

This block is a bus target on a two-wire serial bus that gives a host controller access to a bank of 48 byte-wide registers. The registers sit at pointer values 00h to 2Fh. The serial clock and data lines enter as oversampled inputs in the block's own clock domain. A two-stage synchronizer feeds the edge and bus-condition detectors. The block drives the data line only as an active-high pull-down enable, and an external pull-up sets the line high. A static strap input selects one of two 7-bit device addresses, so two of these blocks can share one bus.

A write transfer carries the device address, a register pointer and one data byte, and the block keeps only that first data byte. A read transfer first sets the pointer with a write. It then uses a repeated start, or a stop followed by a fresh start, to send the read address. The block returns one byte, and the host ends the read with a NACK. The pointer survives a stop, so the second form works.

The control is a state machine with these states:
- ST_IDLE: the bus is free.
- ST_DEV: receiving the address byte.
- ST_DEV_ACK: acknowledging the address.
- ST_PTR: receiving the pointer.
- ST_PTR_ACK: acknowledging the pointer.
- ST_DATA: receiving write data.
- ST_DATA_ACK: acknowledging write data.
- ST_TX: sending the read byte.
- ST_TX_ACK: the host's acknowledge slot.
- ST_HOLD: ignoring traffic until the next start or stop.

Transitions:
- A start moves any state to ST_DEV.
- A stop moves any state to ST_IDLE.
- On the eighth falling SCL edge, ST_DEV goes to ST_DEV_ACK on an address match and to ST_HOLD otherwise. ST_PTR goes to ST_PTR_ACK. ST_DATA goes to ST_DATA_ACK. ST_TX goes to ST_TX_ACK.
- On the ninth falling SCL edge, ST_DEV_ACK goes to ST_TX for a read and to ST_PTR for a write. ST_PTR_ACK goes to ST_DATA. ST_DATA_ACK goes back to ST_DATA. ST_TX_ACK goes to ST_HOLD.

Top module: `i2c_regbank_target`

## Requirements
- R1: With `addr_sel` low, the address bytes C0h (write) and C1h (read) are acknowledged, and C2h is not.
- R2: With `addr_sel` high, the address bytes C2h and C3h are acknowledged, and C0h is not.
- R3: After an address byte that does not match, the block acknowledges nothing, drives nothing and stores nothing until the next start or stop.
- R4: Only a matching address byte, a pointer byte and a write data byte are acknowledged. The acknowledge pulls SDA low from the eighth falling SCL edge to the ninth falling SCL edge, and SDA is released during the eighth data bit.
- R5: In a write, the first data byte after the pointer is stored at the pointer. Further data bytes are acknowledged but stored nowhere.
- R6: A read sends the register at the pointer MSB first. Each bit changes only after a falling SCL edge, and the value is read by the host while SCL is high.
- R7: The pointer is kept across a stop, so a pointer write, a stop and then a read-address transfer returns the register at that pointer.
- R8: Pointer values above 2Fh are acknowledged, writes to them are dropped, and reads from them return 00h.
- R9: After the read byte, the block releases SDA for the host's acknowledge slot. Whether the host sends ACK or NACK, the block then stays silent until a start or stop, so a further byte clocked by the host reads as FFh.
- R10: An SDA fall while SCL is high is a start and restarts address reception, including as a repeated start in the middle of a transfer. An SDA rise while SCL is high is a stop and returns the block to idle. A byte sent after a stop without a new start is not acknowledged.
- R11: Reset clears every register to 00h and the pointer to 00h, and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 1 | Strap that selects the device address (0: C0h/C1h, 1: C2h/C3h) |
| sda_oe | output | 1 | When 1, pull SDA low; when 0, release it |

## Verification
The bound checker watches every clock cycle for five things:
- SDA drive never changes while SCL stays high, unless a start or stop has just been seen.
- The drive is only switched on right after a falling SCL edge.
- A stop always leaves the block idle and released.
- A start always leads into address reception.
- The held state never drives the line.

Only the bench's transfers can show the data-level results:
- The stored and returned byte values.
- Which address and strap pairs are acknowledged.
- That burst bytes and writes above 2Fh are dropped.
- That the pointer survives a stop.
- That reset clears the bank.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_byte_regs.sv
module i2c_byte_regs #(
    parameter int NUM_REGS = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic [7:0] cells [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        localparam logic [7:0] CELL_ADDR = 8'(g);
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (wr_en && wr_addr == CELL_ADDR) begin
                cell_q <= wr_data;
            end
        end
        assign cells[g] = cell_q;
    end

    // Pointers beyond the bank read back as zero
    always_comb begin
        if (int'(rd_addr) < NUM_REGS) begin
            rd_data = cells[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] BASE_ADDR = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic [7:0] ptr,
    output logic [7:0] wr_data,
    output tgt_state_t state,
    output logic       sda_oe
);

    localparam int              CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    tgt_state_t     state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]     rx_sh;
    logic [7:0]     tx_sh;
    logic           rd_q;
    logic           stored;
    logic           full;
    logic           ack_phase;
    logic           addr_hit;

    assign full      = (bit_cnt == FULL);
    assign ack_phase = (state == ST_DEV_ACK) || (state == ST_PTR_ACK) ||
                       (state == ST_DATA_ACK) || (state == ST_TX_ACK);
    assign addr_hit  = (rx_sh[7:1] == (BASE_ADDR | {6'b0, addr_sel}));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_DEV;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_DEV:      if (full) state_nx = addr_hit ? ST_DEV_ACK : ST_HOLD;
                ST_DEV_ACK:  state_nx = rd_q ? ST_TX : ST_PTR;
                ST_PTR:      if (full) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:  state_nx = ST_DATA;
                ST_DATA:     if (full) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: state_nx = ST_DATA;
                ST_TX:       if (full) state_nx = ST_TX_ACK;
                ST_TX_ACK:   state_nx = ST_HOLD;
                ST_IDLE,
                ST_HOLD:     state_nx = state;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Bit counter, shifters, pointer and write-once flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            rd_q    <= 1'b0;
            stored  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            stored  <= 1'b0;
        end else begin
            if (scl_rise) begin
                rx_sh <= {rx_sh[6:0], sda_s};
                if (!full) bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall) begin
                if (full || ack_phase) bit_cnt <= '0;
                if (state == ST_DEV && full) rd_q <= rx_sh[0];
                if (state == ST_PTR && full) begin
                    ptr    <= rx_sh;
                    stored <= 1'b0;
                end
                if (state == ST_DATA && full) stored <= 1'b1;
                if (state == ST_DEV_ACK && rd_q) begin
                    tx_sh <= rd_data;
                end else if (state == ST_TX && !full && bit_cnt != '0) begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign wr_en   = scl_fall && !start_det && !stop_det &&
                     (state == ST_DATA) && full && !stored;
    assign wr_data = rx_sh;

    // Output decode
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_PTR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_TX:                               sda_oe = ~tx_sh[7];
            default:                             sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter int         NUM_REGS    = 48,
    parameter logic [6:0] BASE_ADDR   = 7'h60,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    output logic sda_oe
);

    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_en;
    logic [7:0] ptr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    tgt_state_t state;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .ptr       (ptr),
        .wr_data   (wr_data),
        .state     (state),
        .sda_oe    (sda_oe)
    );

    i2c_byte_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
    import i2c_rb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_t state,
    input logic       sda_oe
);

    // R10: drive is steady while SCL stays high, apart from bus conditions
    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_oe));

    // R4: the pull-down only switches on right after a falling SCL edge
    p_oe_rise_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R10: a stop leaves the block idle and released
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R10: a start always leads into address reception
    p_start_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    // R3: while holding, the block never drives the line
    p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_oe);

endmodule

bind i2c_regbank_target i2c_regbank_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (state),
    .sda_oe    (sda_oe)
);

// File: tb/i2c_regbank_target_test.sv
module i2c_regbank_target_test;

    localparam int Q = 10;

    typedef struct packed {
        logic       is_wr;
        logic [7:0] ptr;
        logic [7:0] val;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 8'h00, 8'hA5},
        '{1'b1, 8'h01, 8'h3C},
        '{1'b1, 8'h2F, 8'h81},
        '{1'b1, 8'h10, 8'h7E},
        '{1'b0, 8'h00, 8'hA5},
        '{1'b0, 8'h2F, 8'h81},
        '{1'b0, 8'h10, 8'h7E},
        '{1'b0, 8'h01, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;

    assign sda_line = ~(m_sda_low | sda_oe);

    always #4 clk = ~clk;

    i2c_regbank_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe)
    );

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl = 1'b1; wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b0; wq();
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack,
                             output logic oe_pre, output logic oe_post);
        oe_pre = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wq();
            m_scl = 1'b1; wq();
            if (i == 0) oe_pre = sda_oe;
            wq();
            m_scl = 1'b0; wq();
        end
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line; wq();
        m_scl = 1'b0; wq();
        oe_post = sda_oe;
    endtask

    task automatic recv_byte(input logic ack_low, output logic [7:0] d, output logic oe9);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            d[i] = sda_line; wq();
            m_scl = 1'b0; wq();
        end
        m_sda_low = ack_low; wq();
        m_scl = 1'b1; wq();
        oe9 = sda_oe; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wr_txn(input logic [7:0] dev, input logic [7:0] p, input logic [7:0] d,
                          output logic [2:0] acks);
        logic a, x, y;
        bus_start();
        send_byte(dev, a, x, y); acks[2] = a;
        send_byte(p, a, x, y);   acks[1] = a;
        send_byte(d, a, x, y);   acks[0] = a;
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] dev, input logic [7:0] p,
                          output logic [7:0] d, output logic [2:0] acks);
        logic a, x, y, o9;
        bus_start();
        send_byte(dev, a, x, y);        acks[2] = a;
        send_byte(p, a, x, y);          acks[1] = a;
        bus_rstart();
        send_byte(dev | 8'h01, a, x, y); acks[0] = a;
        recv_byte(1'b0, d, o9);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        logic a, pre, post, o9;

        repeat (5) @(negedge clk);
        chk("R11 sda released in reset", {7'b0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: bank and pointer clear after reset
        rd_txn(8'hC0, 8'h05, d, acks);
        chk("R11 reg 05 after reset", d, 8'h00);

        // Table of writes then reads (R1, R5, R6)
        for (int k = 0; k < 8; k++) begin
            if (VECS[k].is_wr) begin
                wr_txn(8'hC0, VECS[k].ptr, VECS[k].val, acks);
                chk("R1 R5 write acks", {5'b0, acks}, 8'h07);
            end else begin
                rd_txn(8'hC0, VECS[k].ptr, d, acks);
                chk("R1 read acks", {5'b0, acks}, 8'h07);
                chk("R6 read data", d, VECS[k].val);
            end
        end

        // R4: acknowledge placement on a write byte
        bus_start();
        send_byte(8'hC0, a, pre, post);
        chk("R4 released during bit 8", {7'b0, pre}, 8'h00);
        chk("R4 ack present", {7'b0, a}, 8'h01);
        chk("R4 released after ack", {7'b0, post}, 8'h00);
        send_byte(8'h20, a, pre, post);
        send_byte(8'h5A, a, pre, post);
        bus_stop();
        rd_txn(8'hC0, 8'h20, d, acks);
        chk("R4 data after ack check", d, 8'h5A);

        // R1, R3: wrong address is ignored
        wr_txn(8'hC2, 8'h00, 8'h55, acks);
        chk("R1 R3 no acks for C2", {5'b0, acks}, 8'h00);
        rd_txn(8'hC0, 8'h00, d, acks);
        chk("R3 reg 00 untouched", d, 8'hA5);

        // R2: strap high moves the address
        addr_sel = 1'b1;
        wq();
        wr_txn(8'hC2, 8'h05, 8'h99, acks);
        chk("R2 C2 write acks", {5'b0, acks}, 8'h07);
        rd_txn(8'hC2, 8'h05, d, acks);
        chk("R2 C3 read acks", {5'b0, acks}, 8'h07);
        chk("R2 read data", d, 8'h99);
        wr_txn(8'hC0, 8'h05, 8'h11, acks);
        chk("R2 C0 rejected", {5'b0, acks}, 8'h00);
        addr_sel = 1'b0;
        wq();
        rd_txn(8'hC0, 8'h05, d, acks);
        chk("R2 reg 05 kept", d, 8'h99);

        // R5: burst writes keep only the first byte
        bus_start();
        send_byte(8'hC0, a, pre, post);
        send_byte(8'h03, a, pre, post);
        send_byte(8'h11, a, pre, post);
        send_byte(8'h22, a, pre, post);
        chk("R5 second burst byte acked", {7'b0, a}, 8'h01);
        send_byte(8'h33, a, pre, post);
        bus_stop();
        rd_txn(8'hC0, 8'h03, d, acks);
        chk("R5 first byte stored", d, 8'h11);
        rd_txn(8'hC0, 8'h04, d, acks);
        chk("R5 next reg untouched", d, 8'h00);

        // R8: pointers above 2Fh
        wr_txn(8'hC0, 8'h30, 8'hEE, acks);
        chk("R8 out-of-range acks", {5'b0, acks}, 8'h07);
        rd_txn(8'hC0, 8'h30, d, acks);
        chk("R8 read 30h", d, 8'h00);
        rd_txn(8'hC0, 8'hFF, d, acks);
        chk("R8 read FFh", d, 8'h00);
        rd_txn(8'hC0, 8'h2F, d, acks);
        chk("R8 top reg intact", d, 8'h81);

        // R7: pointer kept across stop
        bus_start();
        send_byte(8'hC0, a, pre, post);
        send_byte(8'h10, a, pre, post);
        bus_stop();
        bus_start();
        send_byte(8'hC1, a, pre, post);
        chk("R7 read address acked", {7'b0, a}, 8'h01);
        recv_byte(1'b0, d, o9);
        bus_stop();
        chk("R7 data after stop+start", d, 8'h7E);

        // R9: release in ack slot, silent after host ACK
        bus_start();
        send_byte(8'hC0, a, pre, post);
        send_byte(8'h00, a, pre, post);
        bus_rstart();
        send_byte(8'hC1, a, pre, post);
        recv_byte(1'b1, d, o9);
        chk("R9 first byte", d, 8'hA5);
        chk("R9 released in ack slot", {7'b0, o9}, 8'h00);
        recv_byte(1'b0, d, o9);
        chk("R9 silent after ack", d, 8'hFF);
        bus_stop();

        // R10: repeated start mid-transfer, and no start after stop
        bus_start();
        send_byte(8'hC0, a, pre, post);
        send_byte(8'h07, a, pre, post);
        bus_rstart();
        send_byte(8'hC0, a, pre, post);
        send_byte(8'h07, a, pre, post);
        send_byte(8'h42, a, pre, post);
        bus_stop();
        rd_txn(8'hC0, 8'h07, d, acks);
        chk("R10 write after repeated start", d, 8'h42);
        send_byte(8'hC0, a, pre, post);
        chk("R10 no ack without start", {7'b0, a}, 8'h00);
        bus_stop();

        // R11: reset clears stored values
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 sda released in reset again", {7'b0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_txn(8'hC0, 8'h00, d, acks);
        chk("R11 reg 00 cleared", d, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule